// File: doc/BRIEF.md
# Floating-Point Exception Status Register

This block keeps the exception state of a floating-point unit. It tracks five exception classes: invalid operation, divide by zero, overflow, underflow and inexact result. Each class has a sticky cumulative flag and an enable mask. The arithmetic unit drives one pulse per class for each operation. The block then either records the exception in its flag or, when the class is enabled, raises a one-cycle trap that the surrounding logic treats as fatal.

A host register port has separate write strobes for the flag field and the mask field, and a select that chooses which of the two fields appears on the read word. Both fields sit in one 32-bit word. The flags occupy the low bits and the masks occupy bits 20 to 16. All other bits are held at zero.

Top module: `fpx_status_reg`

## Requirements
- R1: After synchronous reset, all flags and all masks are zero and `trap_o` is low with `trap_cause_o` zero.
- R2: Class bit positions are fixed: invalid=0, divide-by-zero=1, overflow=2, underflow=3, inexact=4. An exception pulse on bit i with mask i clear sets flag i, and the flag is visible on the next cycle at word bit i of the flags view (`host_rd_sel_i`=0).
- R3: Flags are sticky. Once set, a flag stays set after the pulse ends and changes only through a host flag write.
- R4: A host flag write (`host_wr_flags_i`=1) loads `host_wdata_i[4:0]` into the flags, so it can clear or set any of them.
- R5: When a host flag write and an untrapped exception on class i fall in the same cycle, flag i ends set.
- R6: A host mask write (`host_wr_masks_i`=1) loads `host_wdata_i[20:16]` into the masks, with mask i at word bit 16+i. The masks view (`host_rd_sel_i`=1) returns them at those same bits, and masks hold their value while no mask write occurs.
- R7: An exception pulse on class i whose mask is set drives `trap_o` high on the next cycle, with bit i set in `trap_cause_o`. Flag i is not set by that pulse.
- R8: `trap_o` lasts one cycle. It is low in any cycle that does not follow a trapping pulse.
- R9: Word bits 31..21 and 15..5 read as zero in both views, and writing ones to them changes no state.
- R10: A mask write in the same cycle as an exception pulse has no effect on how that pulse is judged. The mask values held before the write decide whether the pulse traps or sets the flag.
- R11: The read view responds to `host_rd_sel_i` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_pulse_i | input | 5 | Per-class exception pulses from the arithmetic unit |
| host_wr_flags_i | input | 1 | Host strobe: load the flag field |
| host_wr_masks_i | input | 1 | Host strobe: load the mask field |
| host_wdata_i | input | 32 | Host write word |
| host_rd_sel_i | input | 1 | Read view select: 0 flags, 1 masks |
| host_rdata_o | output | 32 | Host read word |
| trap_o | output | 1 | One-cycle fatal trap pulse |
| trap_cause_o | output | 5 | Classes that caused the current trap |

## Verification
A host write can land in the same cycle as an exception pulse. This happens either as a flag write that races a new flag, or as a mask write that races the trap decision. The bench provokes both collisions on purpose. For a flag write it checks that the written value is merged with the untrapped exceptions, so the new flag ends set. For a mask write it checks that the old masks decide between trap and flag. Separately, the bench sweeps all 32 mask patterns against all 32 pulse patterns and compares the trap cause and the recorded flags with masked and unmasked subsets computed in the bench.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int NUM_EXC  = 5;
    localparam int WORD_W   = 32;
    localparam int FLAG_LSB = 0;
    localparam int MASK_LSB = 16;

    typedef enum logic [2:0] {
        EXC_INVALID   = 3'd0,
        EXC_DIVZERO   = 3'd1,
        EXC_OVERFLOW  = 3'd2,
        EXC_UNDERFLOW = 3'd3,
        EXC_INEXACT   = 3'd4
    } exc_class_e;

    typedef logic [NUM_EXC-1:0] exc_vec_t;
    typedef logic [WORD_W-1:0]  word_t;

    typedef enum logic {
        VIEW_FLAGS = 1'b0,
        VIEW_MASKS = 1'b1
    } view_sel_e;

    typedef struct packed {
        logic     wr_flags;
        logic     wr_masks;
        exc_vec_t flag_data;
        exc_vec_t mask_data;
    } host_wr_t;

    function automatic word_t place_field(exc_vec_t v, int lsb);
        word_t w;
        w = '0;
        w[lsb +: NUM_EXC] = v;
        return w;
    endfunction

    function automatic exc_vec_t pick_field(word_t w, int lsb);
        return w[lsb +: NUM_EXC];
    endfunction

    function automatic word_t view_span();
        return place_field('1, FLAG_LSB) | place_field('1, MASK_LSB);
    endfunction

endpackage

// File: rtl/fpx_exc_cell.sv
module fpx_exc_cell (
    input  logic clk,
    input  logic rst,
    input  logic exc_i,
    input  logic flag_wr_i,
    input  logic flag_wdata_i,
    input  logic mask_wr_i,
    input  logic mask_wdata_i,
    output logic flag_o,
    output logic mask_o,
    output logic trap_req_o
);
    logic flag_q, mask_q;
    logic record;

    always_comb begin
        trap_req_o = exc_i & mask_q;
        record     = exc_i & ~mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (flag_wr_i) flag_q <= flag_wdata_i | record;
            else           flag_q <= flag_q | record;
            if (mask_wr_i) mask_q <= mask_wdata_i;
        end
    end

    assign flag_o = flag_q;
    assign mask_o = mask_q;

    a_r2_unmasked_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (exc_i && !mask_o) |=> flag_o);
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !flag_wr_i) |=> flag_o);
    a_r5_write_race_keeps: assert property (@(posedge clk) disable iff (rst)
        (flag_wr_i && exc_i && !mask_o) |=> flag_o);
    a_r7_trap_skips_flag: assert property (@(posedge clk) disable iff (rst)
        (exc_i && mask_o && !flag_o && !flag_wr_i) |=> !flag_o);
    a_r6_mask_loads: assert property (@(posedge clk) disable iff (rst)
        mask_wr_i |=> (mask_o == $past(mask_wdata_i)));
    a_r6_mask_holds: assert property (@(posedge clk) disable iff (rst)
        !mask_wr_i |=> $stable(mask_o));
endmodule

// File: rtl/fpx_trap_gen.sv
module fpx_trap_gen #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] trap_req_i,
    output logic         trap_o,
    output logic [N-1:0] trap_cause_o
);
    logic         trap_q;
    logic [N-1:0] cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q  <= 1'b0;
            cause_q <= '0;
        end else begin
            trap_q  <= |trap_req_i;
            cause_q <= trap_req_i;
        end
    end

    assign trap_o       = trap_q;
    assign trap_cause_o = cause_q;

    a_r7_trap_follows: assert property (@(posedge clk) disable iff (rst)
        (|trap_req_i) |=> (trap_o && trap_cause_o == $past(trap_req_i)));
    a_r8_trap_single: assert property (@(posedge clk) disable iff (rst)
        !(|trap_req_i) |=> (!trap_o && trap_cause_o == '0));
endmodule

// File: rtl/fpx_host_view.sv
module fpx_host_view
    import fpx_pkg::*;
(
    input  exc_vec_t  flags_i,
    input  exc_vec_t  masks_i,
    input  view_sel_e sel_i,
    output word_t     rdata_o
);
    always_comb begin
        unique case (sel_i)
            VIEW_FLAGS: rdata_o = place_field(flags_i, FLAG_LSB);
            VIEW_MASKS: rdata_o = place_field(masks_i, MASK_LSB);
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
    import fpx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_EXC-1:0]  exc_pulse_i,
    input  logic                host_wr_flags_i,
    input  logic                host_wr_masks_i,
    input  logic [WORD_W-1:0]   host_wdata_i,
    input  logic                host_rd_sel_i,
    output logic [WORD_W-1:0]   host_rdata_o,
    output logic                trap_o,
    output logic [NUM_EXC-1:0]  trap_cause_o
);
    host_wr_t  wr;
    exc_vec_t  flags, masks, trap_req;
    view_sel_e view;

    always_comb begin
        wr.wr_flags  = host_wr_flags_i;
        wr.wr_masks  = host_wr_masks_i;
        wr.flag_data = pick_field(host_wdata_i, FLAG_LSB);
        wr.mask_data = pick_field(host_wdata_i, MASK_LSB);
        view         = view_sel_e'(host_rd_sel_i);
    end

    for (genvar i = 0; i < NUM_EXC; i++) begin : g_cell
        fpx_exc_cell u_cell (
            .clk          (clk),
            .rst          (rst),
            .exc_i        (exc_pulse_i[i]),
            .flag_wr_i    (wr.wr_flags),
            .flag_wdata_i (wr.flag_data[i]),
            .mask_wr_i    (wr.wr_masks),
            .mask_wdata_i (wr.mask_data[i]),
            .flag_o       (flags[i]),
            .mask_o       (masks[i]),
            .trap_req_o   (trap_req[i])
        );
    end

    fpx_trap_gen #(.N(NUM_EXC)) u_trap (
        .clk          (clk),
        .rst          (rst),
        .trap_req_i   (trap_req),
        .trap_o       (trap_o),
        .trap_cause_o (trap_cause_o)
    );

    fpx_host_view u_view (
        .flags_i (flags),
        .masks_i (masks),
        .sel_i   (view),
        .rdata_o (host_rdata_o)
    );

    a_r9_unused_zero: assert property (@(posedge clk) disable iff (rst)
        (host_rdata_o & ~view_span()) == '0);
    a_r10_old_mask_rules: assert property (@(posedge clk) disable iff (rst)
        (host_wr_masks_i && (|(exc_pulse_i & masks))) |=> trap_o);
endmodule

// File: tb/fpx_status_reg_bench.sv
`timescale 1ns/1ps
module fpx_status_reg_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  exc;
    logic        wr_f, wr_m, rd_sel;
    logic [31:0] wdata, rdata;
    logic        trap;
    logic [4:0]  cause;
    int          n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    fpx_status_reg u_fpx_status_reg (
        .clk(clk), .rst(rst), .exc_pulse_i(exc),
        .host_wr_flags_i(wr_f), .host_wr_masks_i(wr_m),
        .host_wdata_i(wdata), .host_rd_sel_i(rd_sel),
        .host_rdata_o(rdata), .trap_o(trap), .trap_cause_o(cause)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        exc = '0; wr_f = 0; wr_m = 0; wdata = '0;
    endtask

    task automatic read_flags(output logic [31:0] v);
        rd_sel = 0; #0.5; v = rdata;
    endtask

    task automatic read_masks(output logic [31:0] v);
        rd_sel = 1; #0.5; v = rdata;
    endtask

    initial begin
        logic [31:0] v;
        rst = 1; idle(); rd_sel = 0;
        tick(); tick();
        rst = 0;
        read_flags(v); chk("R1 flags", v, 0);
        read_masks(v); chk("R1 masks", v, 0);
        chk("R1 trap", {31'd0, trap}, 0);
        chk("R1 cause", {27'd0, cause}, 0);

        // R2/R7/R8/R3/R6 exhaustive sweep of masks x pulses
        for (int m = 0; m < 32; m++) begin
            for (int e = 0; e < 32; e++) begin
                wr_f = 1; wr_m = 1; wdata = 32'(m) << 16;
                tick();
                idle(); exc = 5'(e);
                tick();
                idle();
                chk("R7 trap", {31'd0, trap}, {31'd0, ((e & m) != 0)});
                chk("R7 cause", {27'd0, cause}, 32'(e & m));
                read_flags(v); chk("R2 flags", v, 32'(e & ~m & 31));
                tick();
                chk("R8 trap drop", {31'd0, trap}, 0);
                read_flags(v); chk("R3 sticky", v, 32'(e & ~m & 31));
                read_masks(v); chk("R6 mask view", v, 32'(m) << 16);
            end
        end

        // R4: host write loads flags, then clears them
        wr_f = 1; wr_m = 1; wdata = 32'h0000_0015; tick(); idle();
        read_flags(v); chk("R4 load", v, 32'h15);
        wr_f = 1; wdata = 32'h0000_0004; tick(); idle();
        read_flags(v); chk("R4 clear", v, 32'h04);

        // R5: flag write clears while class 1 raised unmasked
        wr_f = 1; wdata = 32'h0; exc = 5'b00010; tick(); idle();
        read_flags(v); chk("R5 race", v, 32'h02);

        // R10: mask write of all ones with pulses on all; old masks (0) rule
        wr_f = 1; wdata = 32'h0; tick(); idle();
        wr_m = 1; wdata = 32'h001F_0000; exc = 5'h1F; tick(); idle();
        chk("R10 no trap", {31'd0, trap}, 0);
        read_flags(v); chk("R10 flags", v, 32'h1F);
        // R10: clear masks while pulse on class 3 with mask set -> trap
        wr_f = 1; wdata = 32'h0; tick(); idle();
        wr_m = 1; wdata = 32'h0; exc = 5'b01000; tick(); idle();
        chk("R10 trap old mask", {27'd0, cause}, 32'h08);
        read_flags(v); chk("R10 no flag", v, 0);

        // R9: ones everywhere
        wr_f = 1; wr_m = 1; wdata = 32'hFFFF_FFFF; tick(); idle();
        read_flags(v); chk("R9 flags view", v, 32'h0000_001F);
        read_masks(v); chk("R9 masks view", v, 32'h001F_0000);

        // R11: view switches without a clock edge
        wr_f = 1; wr_m = 1; wdata = 32'h0005_0003; tick(); idle();
        rd_sel = 0; #0.5; chk("R11 flags", rdata, 32'h3);
        rd_sel = 1; #0.5; chk("R11 masks", rdata, 32'h0005_0000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule